// File: doc/BRIEF.md
# SDRAM Burst Engine with Clock Suspend

This block is the device side of a synchronous DRAM data path, reduced to one bank and a small word store. A registered command bus carries no-operation, activate, precharge, read and write codes together with a column address. A read returns a burst of four words after a fixed CAS latency of two cycles. A write takes its first word with the command and the next three words on the following clock edges. Column addresses step upward inside the aligned group of four words and wrap around inside that group.

The clock-enable input lets the controller freeze the device in the middle of a burst. If clock enable is sampled low while the bank is open, the device stops on the following edge. From then on the burst counter, the column address, the latency pipeline and the output all hold their values. Commands on the bus are ignored, and write data is masked. If clock enable is sampled high again, the device runs from the edge after that one and continues the burst with the next beat, so no beat is lost and none is repeated. If clock enable is low while no bank is open, nothing is frozen.

Top module: `sdr_burst_engine`

## Requirements
- R1: The command codes are 0 no-op, 1 activate, 2 precharge, 3 read and 4 write. Other codes act as no-op. Activate opens the bank and precharge closes it. A read or write given while the bank is closed does nothing.
- R2: The first read word appears on `dout`, with `dout_valid` high, after the second rising edge following the edge that samples the read command. The four words then follow on consecutive edges. `dout_valid` is low whenever no read word is being presented.
- R3: The column addresses of a burst start at the given address and count up modulo 4 in the two low bits. The upper bits stay fixed.
- R4: A write stores `din` at the edge that samples the write command and at each of the next three running edges, at the burst column addresses. Outside a write burst, `din` is never stored.
- R5: If clock enable is sampled low while the bank is open, that edge still advances the burst, and the next edge is frozen.
- R6: After clock enable is sampled high during a suspension, the edge that samples it is still frozen, and the edge after it runs.
- R7: During frozen edges of a read burst, `dout` and `dout_valid` keep their last values.
- R8: Write data sampled on frozen edges is not stored. After exit, the write burst continues with its next beat and column.
- R9: Commands sampled on frozen edges have no effect.
- R10: Clock enable low while the bank is closed does not suspend the device and changes no state.
- R11: A synchronous active-low reset closes the bank, ends any burst, clears the suspension and drives `dout_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low with the bank open suspends the device |
| cmd | input | 3 | Command code (see R1) |
| addr | input | COL_W | Column address of a read or write |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_valid | output | 1 | High while a read word is presented |

## Verification
The bench uses the default parameters: 16-bit words, a 4-bit column (sixteen words), a burst of four and a CAS latency of two. With these values every burst crosses a group boundary when it starts at an offset other than zero, so the wrap is visible in the output order. A two-stage latency path means a read suspension catches words that are still inside the pipeline and lets the bench see that none is lost. The store is small enough that each address is written with a known value before it is read back. This lets the bench confirm that masked writes and ignored commands left the store unchanged.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP   = 3'd0,
        CMD_ACT   = 3'd1,
        CMD_PRE   = 3'd2,
        CMD_READ  = 3'd3,
        CMD_WRITE = 3'd4
    } sdr_cmd_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RD   = 2'd1,
        SEQ_WR   = 2'd2
    } seq_mode_e;

endpackage

// File: rtl/sdr_suspend_ctl.sv
// Tracks the registered suspension; run is low on frozen edges.
module sdr_suspend_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic bank_act,
    output logic run
);
    typedef struct packed {
        logic susp;
    } susp_state_t;

    susp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // low enable only freezes with the bank open; high enable releases
        st_d.susp = !cke && bank_act;
        run = !st_q.susp;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sdr_burst_seq.sv
// Burst beat counter and column stepping with wrap inside the aligned group.
module sdr_burst_seq
    import sdr_pkg::*;
#(
    parameter int COL_W     = 4,
    parameter int BURST_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start_rd,
    input  logic             start_wr,
    input  logic [COL_W-1:0] addr,
    output logic             rd_issue,
    output logic             wr_en,
    output logic [COL_W-1:0] acc_col
);
    localparam int OFS_W = $clog2(BURST_LEN);
    localparam int CNT_W = $clog2(BURST_LEN + 1);

    typedef struct packed {
        seq_mode_e        mode;
        logic [COL_W-1:0] col;
        logic [CNT_W-1:0] left;
    } seq_state_t;

    seq_state_t st_d, st_q;

    function automatic logic [COL_W-1:0] step_col(input logic [COL_W-1:0] c);
        logic [OFS_W-1:0] low;
        low = c[OFS_W-1:0] + 1'b1;
        return {c[COL_W-1:OFS_W], low};
    endfunction

    always_comb begin
        st_d     = st_q;
        rd_issue = 1'b0;
        wr_en    = 1'b0;
        acc_col  = st_q.col;
        if (run) begin
            if (start_wr) begin
                // first write word travels with the command
                wr_en     = 1'b1;
                acc_col   = addr;
                st_d.mode = SEQ_WR;
                st_d.col  = step_col(addr);
                st_d.left = CNT_W'(BURST_LEN - 1);
            end else if (start_rd) begin
                st_d.mode = SEQ_RD;
                st_d.col  = addr;
                st_d.left = CNT_W'(BURST_LEN);
            end else if (st_q.mode != SEQ_IDLE) begin
                if (st_q.mode == SEQ_RD) rd_issue = 1'b1;
                else                     wr_en    = 1'b1;
                st_d.col  = step_col(st_q.col);
                st_d.left = st_q.left - 1'b1;
                if (st_q.left == CNT_W'(1)) st_d.mode = SEQ_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{mode: SEQ_IDLE, col: '0, left: '0};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sdr_cas_pipe.sv
// Read latency pipeline; every stage holds when run is low.
module sdr_cas_pipe #(
    parameter int DATA_W  = 16,
    parameter int CAS_LAT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    localparam int STAGES = CAS_LAT - 1;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } beat_t;

    typedef struct packed {
        beat_t [STAGES-1:0] stage;
        beat_t              out;
    } pipe_state_t;

    pipe_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run) begin
            st_d.stage[0] = '{vld: in_vld, data: in_data};
            for (int i = 1; i < STAGES; i++) begin
                st_d.stage[i] = st_q.stage[i-1];
            end
            st_d.out.vld = st_q.stage[STAGES-1].vld;
            if (st_q.stage[STAGES-1].vld) st_d.out.data = st_q.stage[STAGES-1].data;
        end
        out_vld  = st_q.out.vld;
        out_data = st_q.out.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/sdr_word_store.sv
// Small word array: registered write, combinational read.
module sdr_word_store #(
    parameter int DATA_W = 16,
    parameter int COL_W  = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[col] <= wdata;
    end

    assign rdata = mem_q[col];
endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine
    import sdr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int COL_W     = 4,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic [2:0]        cmd,
    input  logic [COL_W-1:0]  addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid
);
    typedef struct packed {
        logic bank;
    } top_state_t;

    top_state_t        st_d, st_q;
    sdr_cmd_e          cmd_e;
    logic              bank_act;
    logic              run;
    logic              start_rd, start_wr;
    logic              rd_issue, wr_en;
    logic [COL_W-1:0]  acc_col;
    logic [DATA_W-1:0] rd_word;

    assign bank_act = st_q.bank;

    sdr_suspend_ctl u_susp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .bank_act (bank_act),
        .run      (run)
    );

    // command decode; a frozen edge accepts nothing
    always_comb begin
        cmd_e    = sdr_cmd_e'(cmd);
        st_d     = st_q;
        start_rd = 1'b0;
        start_wr = 1'b0;
        if (run) begin
            case (cmd_e)
                CMD_ACT:   st_d.bank = 1'b1;
                CMD_PRE:   st_d.bank = 1'b0;
                CMD_READ:  start_rd  = st_q.bank;
                CMD_WRITE: start_wr  = st_q.bank;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sdr_burst_seq #(
        .COL_W     (COL_W),
        .BURST_LEN (BURST_LEN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .start_rd (start_rd),
        .start_wr (start_wr),
        .addr     (addr),
        .rd_issue (rd_issue),
        .wr_en    (wr_en),
        .acc_col  (acc_col)
    );

    sdr_word_store #(
        .DATA_W (DATA_W),
        .COL_W  (COL_W)
    ) u_store (
        .clk   (clk),
        .we    (wr_en),
        .col   (acc_col),
        .wdata (din),
        .rdata (rd_word)
    );

    sdr_cas_pipe #(
        .DATA_W  (DATA_W),
        .CAS_LAT (CAS_LAT)
    ) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .in_vld   (rd_issue),
        .in_data  (rd_word),
        .out_vld  (dout_valid),
        .out_data (dout)
    );
endmodule

// File: rtl/sdr_burst_engine_chk.sv
module sdr_burst_engine_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              bank_act,
    input logic              run,
    input logic              rd_issue,
    input logic              wr_en,
    input logic [DATA_W-1:0] dout,
    input logic              dout_valid
);
    // R5
    suspend_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && bank_act) |=> !run);

    // R6
    suspend_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !run) |=> run);

    // R7
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> ($stable(dout) && $stable(dout_valid)));

    // R8
    write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> run);

    // R9
    frozen_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(bank_act));

    // R10
    closed_bank_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_act |=> run);

    // R2
    beat_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_issue, wr_en}));
endmodule

bind sdr_burst_engine sdr_burst_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .bank_act   (bank_act),
    .run        (run),
    .rd_issue   (rd_issue),
    .wr_en      (wr_en),
    .dout       (dout),
    .dout_valid (dout_valid)
);

// File: tb/sdr_burst_engine_test.sv
module sdr_burst_engine_test;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cke = 1'b1;
    logic [2:0]    cmd = 3'd0;
    logic [CW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdr_burst_engine uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd),
        .addr(addr), .din(din), .dout(dout), .dout_valid(dout_valid)
    );

    localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, PRE = 3'd2, RD = 3'd3, WR = 3'd4;

    typedef struct packed {
        logic          cke;
        logic [2:0]    cmd;
        logic [CW-1:0] addr;
        logic [DW-1:0] din;
        logic          vld;
        logic [DW-1:0] dat;
        logic [3:0]    req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        '{1'b1, ACT, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd1},  // R1 open bank
        '{1'b1, WR,  4'h5, 16'h1A00, 1'b0, 16'h0000, 4'd4},  // R4 cols 5,6,7,4
        '{1'b1, NOP, 4'h0, 16'h1A11, 1'b0, 16'h0000, 4'd4},
        '{1'b1, NOP, 4'h0, 16'h1A22, 1'b0, 16'h0000, 4'd4},
        '{1'b1, NOP, 4'h0, 16'h1A33, 1'b0, 16'h0000, 4'd4},
        '{1'b1, NOP, 4'h0, 16'hFFFF, 1'b0, 16'h0000, 4'd4},  // idle din
        '{1'b1, RD,  4'h6, 16'h0000, 1'b0, 16'h0000, 4'd2},  // R2 read at 6
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd2},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h1A11, 4'd2},  // latency 2
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h1A22, 4'd3},
        '{1'b0, NOP, 4'h0, 16'h0000, 1'b1, 16'h1A33, 4'd5},  // R5 entry edge runs, R3 wrap
        '{1'b0, WR,  4'h4, 16'hDEAD, 1'b1, 16'h1A33, 4'd7},  // R7 held
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h1A33, 4'd6},  // R6 still frozen
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h1A00, 4'd6},  // resumes
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd2},
        '{1'b1, WR,  4'h0, 16'h2B00, 1'b0, 16'h0000, 4'd4},
        '{1'b0, NOP, 4'h0, 16'h2B11, 1'b0, 16'h0000, 4'd5},
        '{1'b0, NOP, 4'h0, 16'hDEAD, 1'b0, 16'h0000, 4'd8},  // R8 masked
        '{1'b1, NOP, 4'h0, 16'hBEEF, 1'b0, 16'h0000, 4'd8},
        '{1'b1, NOP, 4'h0, 16'h2B22, 1'b0, 16'h0000, 4'd8},
        '{1'b1, NOP, 4'h0, 16'h2B33, 1'b0, 16'h0000, 4'd4},
        '{1'b1, RD,  4'h0, 16'h0000, 1'b0, 16'h0000, 4'd2},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd2},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h2B00, 4'd8},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h2B11, 4'd8},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h2B22, 4'd8},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h2B33, 4'd8},
        '{1'b1, RD,  4'h4, 16'h0000, 1'b0, 16'h0000, 4'd2},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd2},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h1A33, 4'd9},  // R9 frozen write lost
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h1A00, 4'd4},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h1A11, 4'd4},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h1A22, 4'd3},
        '{1'b1, PRE, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd1},  // close bank
        '{1'b0, RD,  4'h0, 16'h0000, 1'b0, 16'h0000, 4'd10}, // R10 no suspend
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd1},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd1},  // closed-bank read ignored
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd10},
        '{1'b0, ACT, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd10},
        '{1'b1, RD,  4'h2, 16'h0000, 1'b0, 16'h0000, 4'd10},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd2},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h2B22, 4'd10},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h2B33, 4'd3},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h2B00, 4'd3},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b1, 16'h2B11, 4'd3},
        '{1'b1, NOP, 4'h0, 16'h0000, 1'b0, 16'h0000, 4'd2}
    };

    task automatic step(input logic c, input logic [2:0] k,
                        input logic [CW-1:0] a, input logic [DW-1:0] d);
        cke = c; cmd = k; addr = a; din = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input int req, input int tag, input logic ev, input logic [DW-1:0] ed);
        checks++;
        if (dout_valid !== ev || (ev && dout !== ed)) begin
            failures++;
            $display("FAIL R%0d step %0d: valid=%0b dout=%h expected valid=%0b dout=%h",
                     req, tag, dout_valid, dout, ev, ed);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(11, -1, 1'b0, '0);  // R11 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].cke, VEC[i].cmd, VEC[i].addr, VEC[i].din);
            check(int'(VEC[i].req), i, VEC[i].vld, VEC[i].dat);
        end
        // R11: reset in the middle of a read burst
        step(1'b1, RD, 4'h0, '0);
        step(1'b1, NOP, 4'h0, '0);
        step(1'b1, NOP, 4'h0, '0);
        check(2, 100, 1'b1, 16'h2B00);
        rst_n = 1'b0;
        step(1'b1, NOP, 4'h0, '0);
        check(11, 101, 1'b0, '0);
        rst_n = 1'b1;
        // R11: bank closed by reset, so this read is dropped
        step(1'b1, RD, 4'h0, '0);
        for (int j = 0; j < 5; j++) begin
            step(1'b1, NOP, 4'h0, '0);
            check(11, 102 + j, 1'b0, '0);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule